// File: doc/BRIEF.md
# Sectioned GPIO Controller with Interrupts

This block is a memory-mapped general-purpose I/O peripheral for 32 pins. The pins are grouped into four independent sections of eight. Every section carries an identical set of byte-wide registers:

- pin direction
- output latch
- synchronized input
- raw and masked interrupt status
- interrupt mask, with separate write ports for masking and unmasking
- per-pin choice between level and latched-edge interrupts

A simple 32-bit register bus reaches the block. It uses an 8-bit byte address and separate read and write strobes, and it returns read data one cycle later.

Software uses the direction register to pick which pins the block drives. The block presents pad tristate control as an output-enable vector, where a 1 means the pad is driven. Incoming pin levels first pass through a two-flop synchronizer. Interrupt detection then works on the synchronized values. Edge-mode pins latch a status bit on a rising edge. Level-mode pins keep their status bit set for as long as the input stays high. One interrupt line carries the OR of every unmasked status bit across all four sections.

Top module: `sgpio_ctrl`

## Requirements
- R1: The address byte selects the section in bits [7:6] and the register offset in bits [5:0]. Pin n sits in section n/8 at bit n%8, so section 1 bit 2 is pin 10. Register data occupies bus bits [7:0], and the upper read bits are zero. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd` high.
- R2: Offset 0x10 holds direction, where 1 means input and 0 means output, and `pin_oe[n]` is 1 exactly when pin n is an output. Offset 0x14 holds the output latch, which can be read and written and drives `pin_out`.
- R3: Offset 0x18 reads the pin inputs after a two-flop synchronizer. Writes to 0x18 change no register.
- R4: Offset 0x04 reads the raw interrupt status. A write to 0x04 clears only the status bits written as 1.
- R5: Offset 0x0C is write-only and reads as zero. Writing 1s sets the matching mask bits.
- R6: Offset 0x08 reads the mask. Writing 1s to 0x08 clears the matching mask bits.
- R7: Offset 0x00 reads the status with masked bits removed. `irq` is the OR of the masked status of all sections.
- R8: Offset 0x20 holds the mode, where 1 means level and 0 means edge. A level-mode status bit is set whenever the synchronized input is high, so it sets again straight after a clear while the input stays high.
- R9: An edge-mode status bit is set once, on a rising edge of the synchronized input. Clearing it while the input stays high leaves it clear.
- R10: Reset leaves these values: all pins inputs, output latch 0, every interrupt masked, status clear, and every pin in edge mode. Unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, bits [7:0] used |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enable, 1 drives |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle:
- the reset values of the section registers;
- that a mask write sets every bit written as 1 and an unmask write clears it;
- that a write to the input offset leaves every register unchanged;
- that a level-mode bit with its input high is set on the next cycle, whatever clear arrives.

Only the bench scenarios can show the end-to-end behaviour seen from the ports:
- the synchronizer latency;
- one status bit per edge, and no re-latch after a clear while the input is held;
- the masked-status view and the combined interrupt line;
- the address-to-pin mapping across sections;
- that unused and write-only offsets read zero.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

    localparam int SECT_W    = 8;
    localparam int NUM_SECT  = 4;
    localparam int OFF_W     = 6;
    localparam int SEL_W     = $clog2(NUM_SECT);
    localparam int PINS      = SECT_W * NUM_SECT;

    typedef enum logic [OFF_W-1:0] {
        OFF_MSTAT  = 6'h00,
        OFF_STAT   = 6'h04,
        OFF_UNMASK = 6'h08,
        OFF_MASK   = 6'h0C,
        OFF_DIR    = 6'h10,
        OFF_OUT    = 6'h14,
        OFF_IN     = 6'h18,
        OFF_MODE   = 6'h20
    } reg_off_e;

    typedef struct packed {
        logic              wr;
        logic [OFF_W-1:0]  off;
        logic [SECT_W-1:0] wd;
    } sect_req_t;

    function automatic logic is_wr(sect_req_t r, reg_off_e o);
        return r.wr && (r.off == o);
    endfunction

endpackage

// File: rtl/sgpio_sync.sv
module sgpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/sgpio_section.sv
module sgpio_section
    import sgpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sect_req_t         req,
    input  logic [SECT_W-1:0] pins_raw,
    output logic [SECT_W-1:0] rd_val,
    output logic [SECT_W-1:0] drv_out,
    output logic [SECT_W-1:0] drv_oe,
    output logic              sect_irq
);
    logic [SECT_W-1:0] dir_q, out_q, mask_q, mode_q, stat_q;
    logic [SECT_W-1:0] sync_in, prev_q, set_v, clr_v, masked;

    sgpio_sync #(.W(SECT_W)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (sync_in)
    );

    // Level pins raise status on high input, edge pins on rising edge.
    assign set_v  = (mode_q & sync_in) | (~mode_q & sync_in & ~prev_q);
    assign clr_v  = is_wr(req, OFF_STAT) ? req.wd : '0;
    assign masked = stat_q & ~mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            out_q  <= '0;
            mask_q <= '1;
            mode_q <= '0;
            stat_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= sync_in;
            stat_q <= (stat_q & ~clr_v) | set_v;
            if (is_wr(req, OFF_DIR))    dir_q  <= req.wd;
            if (is_wr(req, OFF_OUT))    out_q  <= req.wd;
            if (is_wr(req, OFF_MODE))   mode_q <= req.wd;
            if (is_wr(req, OFF_MASK))   mask_q <= mask_q | req.wd;
            if (is_wr(req, OFF_UNMASK)) mask_q <= mask_q & ~req.wd;
        end
    end

    always_comb begin
        case (req.off)
            OFF_MSTAT:  rd_val = masked;
            OFF_STAT:   rd_val = stat_q;
            OFF_UNMASK: rd_val = mask_q;
            OFF_DIR:    rd_val = dir_q;
            OFF_OUT:    rd_val = out_q;
            OFF_IN:     rd_val = sync_in;
            OFF_MODE:   rd_val = mode_q;
            default:    rd_val = '0;
        endcase
    end

    assign drv_out  = out_q;
    assign drv_oe   = ~dir_q;
    assign sect_irq = |masked;

    // R10: reset values
    assert_reset_vals_R10: assert property (@(posedge clk)
        rst |=> (dir_q == '1 && mask_q == '1 && stat_q == '0 && mode_q == '0 && out_q == '0));

    // R5: mask write sets written bits
    assert_mask_set_R5: assert property (@(posedge clk) disable iff (rst)
        is_wr(req, OFF_MASK) |=> ((mask_q & $past(req.wd)) == $past(req.wd)));

    // R6: unmask write clears written bits
    assert_unmask_clr_R6: assert property (@(posedge clk) disable iff (rst)
        is_wr(req, OFF_UNMASK) |=> ((mask_q & $past(req.wd)) == '0));

    // R3: input offset is read-only
    assert_input_ro_R3: assert property (@(posedge clk) disable iff (rst)
        is_wr(req, OFF_IN) |=> ($stable(dir_q) && $stable(out_q) && $stable(mask_q) && $stable(mode_q)));

    // R8: level-mode bit with high input is set next cycle despite clears
    assert_level_reassert_R8: assert property (@(posedge clk) disable iff (rst)
        ((mode_q & sync_in) != '0) |=> ((stat_q & $past(mode_q & sync_in)) == $past(mode_q & sync_in)));

endmodule

// File: rtl/sgpio_ctrl.sv
module sgpio_ctrl
    import sgpio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe,
    output logic        irq
);
    logic [SEL_W-1:0]  sel;
    logic [OFF_W-1:0]  off;
    logic [SECT_W-1:0] rd_arr [NUM_SECT];
    logic [NUM_SECT-1:0] irq_v;
    logic [31-SECT_W:0] unused_wdata_hi;

    assign sel = bus_addr[OFF_W +: SEL_W];
    assign off = bus_addr[OFF_W-1:0];
    assign unused_wdata_hi = bus_wdata[31:SECT_W];

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        sect_req_t r;
        assign r.wr  = bus_wr && (sel == s[SEL_W-1:0]);
        assign r.off = off;
        assign r.wd  = bus_wdata[SECT_W-1:0];

        sgpio_section sect_i (
            .clk      (clk),
            .rst      (rst),
            .req      (r),
            .pins_raw (pin_in[s*SECT_W +: SECT_W]),
            .rd_val   (rd_arr[s]),
            .drv_out  (pin_out[s*SECT_W +: SECT_W]),
            .drv_oe   (pin_oe[s*SECT_W +: SECT_W]),
            .sect_irq (irq_v[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= {{(32-SECT_W){1'b0}}, rd_arr[sel]};
    end

    assign irq = |irq_v;

    // R1: upper read bits stay zero
    assert_rdata_hi_zero_R1: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:SECT_W] == '0);

endmodule

// File: tb/sgpio_ctrl_tb_top.sv
module sgpio_ctrl_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [31:0] pin_in = 0, pin_out, pin_oe;
    logic        irq;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sgpio_ctrl dut_i (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = {24'hABCDEF, d}; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        v = bus_rdata;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R10 oe", pin_oe, 0);
        chk("R10 out", pin_out, 0);
        chk("R10 irq", {31'b0, irq}, 0);
        rd(8'h10, v); chk("R10 dir", v, 32'hFF);
        rd(8'h48, v); chk("R10 mask", v, 32'hFF);
        rd(8'hA0, v); chk("R10 mode", v, 0);
        rd(8'hC4, v); chk("R10 status", v, 0);
        rd(8'h24, v); chk("R10 unused", v, 0);
        rd(8'h0C, v); chk("R5 write-only reads 0", v, 0);
    endtask

    task automatic t_dir_out();
        logic [31:0] v;
        wr(8'h50, 8'hFB);
        chk("R2 oe pin10", pin_oe, 32'h0000_0400);
        wr(8'h54, 8'h04);
        chk("R1 R2 pin_out pin10", pin_out, 32'h0000_0400);
        rd(8'h54, v); chk("R2 out readback", v, 32'h04);
        rd(8'h50, v); chk("R2 dir readback", v, 32'hFB);
        wr(8'h58, 8'h00);
        rd(8'h54, v); chk("R3 write to input ignored (out)", v, 32'h04);
        rd(8'h50, v); chk("R3 write to input ignored (dir)", v, 32'hFB);
    endtask

    task automatic t_input();
        logic [31:0] v;
        pin_in = 32'h0000_A500;
        wait_cyc(3);
        rd(8'h58, v); chk("R3 input section1", v, 32'hA5);
        rd(8'h18, v); chk("R1 input section0", v, 0);
        pin_in = 0;
        wait_cyc(3);
        wr(8'h44, 8'hFF);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(8'h88, 8'h02);
        rd(8'h88, v); chk("R6 unmask readback", v, 32'hFD);
        pin_in[17] = 1;
        wait_cyc(5);
        rd(8'h84, v); chk("R9 edge status", v, 32'h02);
        rd(8'h80, v); chk("R7 masked status", v, 32'h02);
        chk("R7 irq high", {31'b0, irq}, 1);
        wr(8'h84, 8'h01);
        rd(8'h84, v); chk("R4 clear other bit only", v, 32'h02);
        wr(8'h84, 8'h02);
        wait_cyc(3);
        rd(8'h84, v); chk("R9 no re-latch while high", v, 0);
        chk("R7 irq low", {31'b0, irq}, 0);
        pin_in[17] = 0;
        wait_cyc(3);
        pin_in[17] = 1;
        wait_cyc(5);
        wr(8'h8C, 8'h02);
        rd(8'h80, v); chk("R5 masked view cleared", v, 0);
        rd(8'h84, v); chk("R5 raw status kept", v, 32'h02);
        chk("R5 irq masked", {31'b0, irq}, 0);
        rd(8'h88, v); chk("R5 mask readback", v, 32'hFF);
        pin_in[17] = 0;
        wait_cyc(3);
        wr(8'h84, 8'hFF);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(8'hE0, 8'h01);
        rd(8'hE0, v); chk("R8 mode readback", v, 32'h01);
        wr(8'hC8, 8'h01);
        pin_in[24] = 1;
        wait_cyc(4);
        rd(8'hC4, v); chk("R8 level status", v, 32'h01);
        wr(8'hC4, 8'h01);
        rd(8'hC4, v); chk("R8 reasserts after clear", v, 32'h01);
        chk("R8 irq level", {31'b0, irq}, 1);
        pin_in[24] = 0;
        wait_cyc(4);
        wr(8'hC4, 8'h01);
        rd(8'hC4, v); chk("R8 clears once low", v, 0);
        chk("R7 irq off", {31'b0, irq}, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst = 0;
        wait_cyc(1);
        t_reset();
        t_dir_out();
        t_input();
        t_edge();
        t_level();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule